// File: doc/BRIEF.md
# FIFO Watermark Interrupt and DMA Ready Logic

This block sits beside one serial channel's pair of 128-entry FIFOs and turns their occupancy into service requests for the host. Every cycle it compares the transmit and receive fill counts against a threshold for each direction. From those comparisons it raises a transmit interrupt request and a receive interrupt request. It also drives two active-low DMA handshake pins, one asking the DMA engine to write transmit data and one asking it to read received data.

There are two ways to set the thresholds. If the four 8-bit threshold registers (transmit trigger, receive trigger, flow-high and flow-low) are all zero, each direction takes its level from a 2-bit coded field, as a small 32-byte FIFO would. If any of the four is non-zero, the per-byte transmit and receive trigger registers set the levels directly. A DMA mode select picks how the ready pins behave: either one transfer at a time or block transfers. The block also returns each FIFO's fill count as a registered level output. Every output is registered.

Top module: `fifo_watermark_dma`

## Requirements
- R1: While reset is high, both interrupt requests are 0, both ready pins are 1 (inactive) and both level outputs are 0.
- R2: When the flow-high, flow-low, transmit-trigger and receive-trigger registers are all zero, the levels come from the 2-bit codes. For receive, codes 0,1,2,3 give 8,16,24,28. For transmit, codes 0,1,2,3 give 16,8,24,30.
- R3: When any of those four registers is non-zero, the transmit and receive levels equal the transmit-trigger and receive-trigger values. A value of 0 is reserved and gives 1. A value above 128 gives 128.
- R4: The receive interrupt is 1 while the receive count is at or above the receive level, or while a timeout flag is held. Otherwise it is 0.
- R5: A one-cycle receive-timeout pulse sets the receive interrupt on the next clock edge, whatever the count. The interrupt stays set until the receive count reads 0 with no new timeout.
- R6: The transmit interrupt sets when the transmit count moves from at or above the transmit level to below it. This covers reaching 0, and also the first cycle after reset. It clears when the count returns to the level or above, or when the status-read strobe is high in a cycle where no new set event happens.
- R7: With the FIFO enable at 0, both levels are 1 and the DMA mode select is ignored. The receive interrupt then means "count at least 1", and the transmit interrupt condition means "count is 0".
- R8: In single-transfer DMA mode (select 0, or the FIFO disabled), the transmit ready pin is 0 exactly when the transmit count is 0.
- R9: In block DMA mode (select 1 with the FIFO enabled), the transmit ready pin is 0 while the transmit count is below 128. It is 1 when the count is 128.
- R10: In single-transfer DMA mode, the receive ready pin is 0 exactly when the receive count is at least 1.
- R11: In block DMA mode, the receive ready pin goes to 0 when the receive count reaches the receive level or a timeout pulse arrives. It returns to 1 only when the receive count is 0.
- R12: Every output follows its inputs by exactly one clock. The level outputs repeat the two counts (0 to 128) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable |
| dma_mode | input | 1 | DMA mode select: 0 single transfer, 1 block |
| tx_code | input | 2 | Coded transmit level for compatibility mode |
| rx_code | input | 2 | Coded receive level for compatibility mode |
| tx_trig | input | 8 | Per-byte transmit trigger register |
| rx_trig | input | 8 | Per-byte receive trigger register |
| flow_hi | input | 8 | Flow-control high threshold register (mode decode only) |
| flow_lo | input | 8 | Flow-control low threshold register (mode decode only) |
| tx_count | input | 8 | Transmit FIFO occupancy, 0 to 128 |
| rx_count | input | 8 | Receive FIFO occupancy, 0 to 128 |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| isr_read | input | 1 | Interrupt status read strobe |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| tx_rdy_n | output | 1 | Active-low transmit DMA ready |
| rx_rdy_n | output | 1 | Active-low receive DMA ready |
| tx_level | output | 8 | Registered transmit occupancy |
| rx_level | output | 8 | Registered receive occupancy |

## Verification
The block has three pieces of hidden state: the previous-cycle "below level" bit, the sticky timeout flag and the block-mode receive-ready latch. A fault in any of them appears at a port one clock after the stimulus that should have moved it. For example, a stale below-level bit either re-raises the transmit interrupt after an acknowledge or fails to raise it on a downward crossing. A timeout flag that is not cleared keeps the receive interrupt high after the count drains to 0. A bad receive-ready latch releases the pin before the FIFO is empty. The stimulus deliberately walks each count across its threshold in both directions, and then holds it there, so that these faults show up as a one-cycle mismatch.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BLOCK  = 1'b1
  } dma_mode_e;

  // Compatibility-mode receive levels
  function automatic int legacy_rx_lvl(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 24;
      default: return 28;
    endcase
  endfunction

  // Compatibility-mode transmit levels
  function automatic int legacy_tx_lvl(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 8;
      2'd2:    return 24;
      default: return 30;
    endcase
  endfunction

  // Per-byte level: 0 is reserved and maps to 1, values above depth clamp
  function automatic int ext_lvl(input int raw, input int depth);
    if (raw == 0)     return 1;
    if (raw > depth)  return depth;
    return raw;
  endfunction

endpackage

// File: rtl/fwd_thresh.sv
`timescale 1ns/1ps
module fwd_thresh #(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int TRW   = 8
) (
  input  logic           fifo_en,
  input  logic [1:0]     tx_code,
  input  logic [1:0]     rx_code,
  input  logic [TRW-1:0] tx_trig,
  input  logic [TRW-1:0] rx_trig,
  input  logic [TRW-1:0] flow_hi,
  input  logic [TRW-1:0] flow_lo,
  output logic [CW-1:0]  tx_lvl,
  output logic [CW-1:0]  rx_lvl
);
  import fwd_pkg::*;

  localparam int NDIR = 2;  // index 0 transmit, 1 receive

  logic           ext_mode;
  logic [1:0]     code_a [NDIR];
  logic [TRW-1:0] raw_a  [NDIR];
  logic [CW-1:0]  lvl_a  [NDIR];

  assign ext_mode  = |{tx_trig, rx_trig, flow_hi, flow_lo};
  assign code_a[0] = tx_code;
  assign code_a[1] = rx_code;
  assign raw_a[0]  = tx_trig;
  assign raw_a[1]  = rx_trig;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_comb begin : p_lvl
      int v;
      if (!fifo_en)
        v = 1;
      else if (ext_mode)
        v = ext_lvl(int'(raw_a[d]), DEPTH);
      else if (d == 0)
        v = legacy_tx_lvl(code_a[d]);
      else
        v = legacy_rx_lvl(code_a[d]);
      lvl_a[d] = CW'(v);
    end
  end

  assign tx_lvl = lvl_a[0];
  assign rx_lvl = lvl_a[1];

endmodule

// File: rtl/fwd_rx_path.sv
`timescale 1ns/1ps
module fwd_rx_path #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_lvl,
  input  logic          rx_timeout,
  input  logic          block_mode,
  output logic          rx_irq,
  output logic          rx_rdy_n
);
  logic above, empty;
  logic to_flag_q, to_flag_d;
  logic act_q, act_d;

  assign above     = (rx_count >= rx_lvl);
  assign empty     = (rx_count == '0);
  assign to_flag_d = rx_timeout | (to_flag_q & ~empty);

  always_comb begin
    if (above || rx_timeout)
      act_d = 1'b1;
    else if (empty)
      act_d = 1'b0;
    else
      act_d = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_flag_q <= 1'b0;
      act_q     <= 1'b0;
      rx_irq    <= 1'b0;
      rx_rdy_n  <= 1'b1;
    end else begin
      to_flag_q <= to_flag_d;
      act_q     <= act_d;
      rx_irq    <= above | to_flag_d;
      rx_rdy_n  <= block_mode ? ~act_d : empty;
    end
  end

endmodule

// File: rtl/fwd_tx_path.sv
`timescale 1ns/1ps
module fwd_tx_path #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] tx_lvl,
  input  logic          isr_read,
  input  logic          block_mode,
  output logic          tx_irq,
  output logic          tx_rdy_n
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic below, below_q, set_ev;

  assign below  = (tx_count < tx_lvl);
  assign set_ev = below & ~below_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      below_q  <= 1'b0;
      tx_irq   <= 1'b0;
      tx_rdy_n <= 1'b1;
    end else begin
      below_q <= below;
      if (set_ev)
        tx_irq <= 1'b1;
      else if (!below || isr_read)
        tx_irq <= 1'b0;
      tx_rdy_n <= block_mode ? (tx_count >= FULL) : (tx_count != '0);
    end
  end

endmodule

// File: rtl/fifo_watermark_dma.sv
`timescale 1ns/1ps
module fifo_watermark_dma #(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int TRW   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fifo_en,
  input  logic           dma_mode,
  input  logic [1:0]     tx_code,
  input  logic [1:0]     rx_code,
  input  logic [TRW-1:0] tx_trig,
  input  logic [TRW-1:0] rx_trig,
  input  logic [TRW-1:0] flow_hi,
  input  logic [TRW-1:0] flow_lo,
  input  logic [CW-1:0]  tx_count,
  input  logic [CW-1:0]  rx_count,
  input  logic           rx_timeout,
  input  logic           isr_read,
  output logic           tx_irq,
  output logic           rx_irq,
  output logic           tx_rdy_n,
  output logic           rx_rdy_n,
  output logic [CW-1:0]  tx_level,
  output logic [CW-1:0]  rx_level
);
  import fwd_pkg::*;

  logic [CW-1:0] tx_lvl, rx_lvl;
  logic          block_mode;

  assign block_mode = fifo_en && (dma_mode_e'(dma_mode) == DMA_BLOCK);

  fwd_thresh #(.DEPTH(DEPTH), .CW(CW), .TRW(TRW)) u_thresh (
    .fifo_en (fifo_en),
    .tx_code (tx_code),
    .rx_code (rx_code),
    .tx_trig (tx_trig),
    .rx_trig (rx_trig),
    .flow_hi (flow_hi),
    .flow_lo (flow_lo),
    .tx_lvl  (tx_lvl),
    .rx_lvl  (rx_lvl)
  );

  fwd_rx_path #(.CW(CW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_count   (rx_count),
    .rx_lvl     (rx_lvl),
    .rx_timeout (rx_timeout),
    .block_mode (block_mode),
    .rx_irq     (rx_irq),
    .rx_rdy_n   (rx_rdy_n)
  );

  fwd_tx_path #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tx_count   (tx_count),
    .tx_lvl     (tx_lvl),
    .isr_read   (isr_read),
    .block_mode (block_mode),
    .tx_irq     (tx_irq),
    .tx_rdy_n   (tx_rdy_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_level <= '0;
      rx_level <= '0;
    end else begin
      tx_level <= tx_count;
      rx_level <= rx_count;
    end
  end

endmodule

// File: rtl/fwd_checker.sv
`timescale 1ns/1ps
module fwd_checker #(
  parameter int DEPTH = 128,
  parameter int CW    = 8,
  parameter int TRW   = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           fifo_en,
  input logic           dma_mode,
  input logic [1:0]     tx_code,
  input logic [TRW-1:0] tx_trig,
  input logic [TRW-1:0] rx_trig,
  input logic [TRW-1:0] flow_hi,
  input logic [TRW-1:0] flow_lo,
  input logic [CW-1:0]  tx_count,
  input logic [CW-1:0]  rx_count,
  input logic           rx_timeout,
  input logic           isr_read,
  input logic           tx_irq,
  input logic           rx_irq,
  input logic           tx_rdy_n,
  input logic           rx_rdy_n,
  input logic [CW-1:0]  tx_level,
  input logic [CW-1:0]  rx_level
);
  logic past_ok;
  logic blk;

  assign blk = fifo_en && dma_mode;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_txrdy_full_R9: assert property (@(posedge clk) disable iff (rst)
    (blk && tx_count == CW'(DEPTH)) |=> tx_rdy_n);

  assert_txrdy_room_R9: assert property (@(posedge clk) disable iff (rst)
    (blk && tx_count < CW'(DEPTH)) |=> !tx_rdy_n);

  assert_txrdy_single_R8: assert property (@(posedge clk) disable iff (rst)
    (!blk && tx_count == '0) |=> !tx_rdy_n);

  assert_rxrdy_single_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !blk) |=> (rx_rdy_n == ($past(rx_count) == '0)));

  assert_rxirq_timeout_R5: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |=> rx_irq);

  assert_rxirq_drained_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0 && !rx_timeout) |=> !rx_irq);

  assert_txirq_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && isr_read && $stable(tx_count) && $stable(fifo_en) &&
     $stable(tx_code) && $stable(tx_trig) && $stable(rx_trig) &&
     $stable(flow_hi) && $stable(flow_lo)) |=> !tx_irq);

  assert_level_track_R12: assert property (@(posedge clk) disable iff (rst)
    past_ok |=> (tx_level == $past(tx_count) && rx_level == $past(rx_count)));

endmodule

bind fifo_watermark_dma fwd_checker #(.DEPTH(DEPTH), .CW(CW), .TRW(TRW)) u_fwd_checker (
  .clk        (clk),
  .rst        (rst),
  .fifo_en    (fifo_en),
  .dma_mode   (dma_mode),
  .tx_code    (tx_code),
  .tx_trig    (tx_trig),
  .rx_trig    (rx_trig),
  .flow_hi    (flow_hi),
  .flow_lo    (flow_lo),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .rx_timeout (rx_timeout),
  .isr_read   (isr_read),
  .tx_irq     (tx_irq),
  .rx_irq     (rx_irq),
  .tx_rdy_n   (tx_rdy_n),
  .rx_rdy_n   (rx_rdy_n),
  .tx_level   (tx_level),
  .rx_level   (rx_level)
);

// File: tb/tb_fifo_watermark_dma.sv
`timescale 1ns/1ps
module tb_fifo_watermark_dma;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // stimulus staging (set by the sequence) and driven copies (to the DUT)
  logic       s_fen = 1'b1, s_dm = 1'b0, s_to = 1'b0, s_rd = 1'b0;
  logic [1:0] s_txcode = '0, s_rxcode = '0;
  logic [7:0] s_txtr = '0, s_rxtr = '0, s_fhi = '0, s_flo = '0, s_txc = '0, s_rxc = '0;

  logic       d_fen = 1'b1, d_dm = 1'b0, d_to = 1'b0, d_rd = 1'b0;
  logic [1:0] d_txcode = '0, d_rxcode = '0;
  logic [7:0] d_txtr = '0, d_rxtr = '0, d_fhi = '0, d_flo = '0, d_txc = '0, d_rxc = '0;

  logic       tx_irq, rx_irq, tx_rdy_n, rx_rdy_n;
  logic [7:0] tx_level, rx_level;

  fifo_watermark_dma dut (
    .clk(clk), .rst(rst), .fifo_en(d_fen), .dma_mode(d_dm),
    .tx_code(d_txcode), .rx_code(d_rxcode), .tx_trig(d_txtr), .rx_trig(d_rxtr),
    .flow_hi(d_fhi), .flow_lo(d_flo), .tx_count(d_txc), .rx_count(d_rxc),
    .rx_timeout(d_to), .isr_read(d_rd), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .tx_level(tx_level), .rx_level(rx_level)
  );

  typedef struct {
    bit    tx_irq, rx_irq, tx_rdy_n, rx_rdy_n, blk;
    int    tlev, rlev;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   nchk = 0, nerr = 0;
  bit   done = 1'b0;

  // reference state, from the requirements
  bit m_below_q = 0, m_txirq = 0, m_toflag = 0, m_rxact = 0;

  task automatic chk(input string req, input string nm, input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s (%s) actual=%0d expected=%0d", req, nm, tag, act, exp);
    end
  endtask

  function automatic int leg_rx(input logic [1:0] c);
    int t[4] = '{8, 16, 24, 28};
    return t[c];
  endfunction

  function automatic int leg_tx(input logic [1:0] c);
    int t[4] = '{16, 8, 24, 30};
    return t[c];
  endfunction

  function automatic int pick(input bit fen, input bit ext, input int raw, input int leg);
    if (!fen) return 1;
    if (ext) begin
      if (raw == 0) return 1;
      if (raw > DEPTH) return DEPTH;
      return raw;
    end
    return leg;
  endfunction

  // driver: apply staged inputs at a falling edge, push the expected result
  task automatic step(input string tag);
    exp_t x;
    bit ext, blk, above, below, setev, toflag_n, act_n;
    int rl, tl;
    @(negedge clk);
    rst = 1'b0;
    d_fen = s_fen; d_dm = s_dm; d_to = s_to; d_rd = s_rd;
    d_txcode = s_txcode; d_rxcode = s_rxcode;
    d_txtr = s_txtr; d_rxtr = s_rxtr; d_fhi = s_fhi; d_flo = s_flo;
    d_txc = s_txc; d_rxc = s_rxc;
    ext = (s_txtr | s_rxtr | s_fhi | s_flo) != 0;
    blk = s_fen && s_dm;
    rl  = pick(s_fen, ext, int'(s_rxtr), leg_rx(s_rxcode));
    tl  = pick(s_fen, ext, int'(s_txtr), leg_tx(s_txcode));
    above    = int'(s_rxc) >= rl;
    toflag_n = s_to || (m_toflag && s_rxc != 0);
    act_n    = (above || s_to) ? 1'b1 : (s_rxc == 0) ? 1'b0 : m_rxact;
    below    = int'(s_txc) < tl;
    setev    = below && !m_below_q;
    if (setev) m_txirq = 1'b1;
    else if (!below || s_rd) m_txirq = 1'b0;
    m_below_q = below;
    m_toflag  = toflag_n;
    m_rxact   = act_n;
    x.tx_irq   = m_txirq;
    x.rx_irq   = above || toflag_n;
    x.tx_rdy_n = blk ? (int'(s_txc) >= DEPTH) : (s_txc != 0);
    x.rx_rdy_n = blk ? !act_n : (s_rxc == 0);
    x.blk  = blk;
    x.tlev = int'(s_txc);
    x.rlev = int'(s_rxc);
    x.tag  = tag;
    q.push_back(x);
  endtask

  // monitor: compare a little after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R6", "tx_irq", e.tag, int'(tx_irq), int'(e.tx_irq));
      chk("R4", "rx_irq", e.tag, int'(rx_irq), int'(e.rx_irq));
      chk(e.blk ? "R9" : "R8", "tx_rdy_n", e.tag, int'(tx_rdy_n), int'(e.tx_rdy_n));
      chk(e.blk ? "R11" : "R10", "rx_rdy_n", e.tag, int'(rx_rdy_n), int'(e.rx_rdy_n));
      chk("R12", "tx_level", e.tag, int'(tx_level), e.tlev);
      chk("R12", "rx_level", e.tag, int'(rx_level), e.rlev);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    s_txc = 8'd5;            // count non-zero during reset: outputs must still be at reset values
    d_txc = 8'd5; d_rxc = 8'd9;
    repeat (3) @(negedge clk);
    chk("R1", "tx_irq",   "reset", int'(tx_irq),   0);
    chk("R1", "rx_irq",   "reset", int'(rx_irq),   0);
    chk("R1", "tx_rdy_n", "reset", int'(tx_rdy_n), 1);
    chk("R1", "rx_rdy_n", "reset", int'(rx_rdy_n), 1);
    chk("R1", "tx_level", "reset", int'(tx_level), 0);
    chk("R1", "rx_level", "reset", int'(rx_level), 0);
    s_txc = 0;

    // first cycles after reset: empty transmit FIFO raises the transmit interrupt
    step("R6 idle"); step("R6 idle");

    // R2 receive code 0 -> level 8
    for (int i = 0; i <= 10; i++) begin s_rxc = 8'(i); step("R2 rx code0"); end
    // R2 receive code 3 -> level 28
    s_rxcode = 2'd3;
    s_rxc = 27; step("R2 rx code3");
    s_rxc = 28; step("R2 rx code3");
    s_rxc = 27; step("R2 rx code3");
    s_rxc = 0;  step("R2 rx drain");

    // R6 transmit code 0 -> level 16: fill, cross down, acknowledge
    for (int i = 1; i <= 20; i++) begin s_txc = 8'(i); step("R6 tx fill"); end
    s_txc = 16; step("R6 tx at level");
    s_txc = 15; step("R6 tx cross down");
    step("R6 tx hold");
    s_rd = 1'b1; step("R6 ack");
    s_rd = 1'b0; step("R6 after ack");
    s_txc = 14; step("R6 no re-raise");
    s_txc = 0;  step("R6 empty after ack");
    s_txcode = 2'd1;                 // level 8
    s_txc = 8;  step("R2 tx code1 at level");
    s_txc = 7;  step("R2 tx code1 below");
    s_txcode = 2'd3;                 // level 30
    s_txc = 30; step("R2 tx code3 at level");
    s_txc = 29; step("R2 tx code3 below");

    // R5 receive timeout with count below level
    s_rxcode = 2'd0; s_rxc = 3; step("R5 pre");
    s_to = 1'b1; step("R5 pulse");
    s_to = 1'b0; step("R5 held"); step("R5 held");
    s_rxc = 0; step("R5 drained"); step("R5 idle");

    // R3 per-byte levels
    s_flo = 8'd5;                    // extended mode, trigger registers still 0 -> level 1
    s_rxc = 0; step("R3 zero maps 1");
    s_rxc = 1; step("R3 zero maps 1");
    s_rxtr = 100;
    s_rxc = 99;  step("R3 rx 100");
    s_rxc = 100; step("R3 rx 100");
    s_rxc = 99;  step("R3 rx 100");
    s_rxtr = 200;
    s_rxc = 127; step("R3 clamp 128");
    s_rxc = 128; step("R3 clamp 128");
    s_txtr = 40;
    s_txc = 40; step("R3 tx 40");
    s_txc = 39; step("R3 tx 40");

    // R9 / R11 block DMA mode
    s_dm = 1'b1; s_rxtr = 10;
    s_txc = 126; step("R9 room");
    s_txc = 127; step("R9 room");
    s_txc = 128; step("R9 full");
    s_txc = 127; step("R9 room again");
    s_rxc = 0;  step("R11 empty");
    s_rxc = 5;  step("R11 below level");
    s_rxc = 10; step("R11 reach level");
    s_rxc = 4;  step("R11 hold");
    s_rxc = 1;  step("R11 hold");
    s_rxc = 0;  step("R11 release");
    s_rxc = 2;  step("R11 below again");
    s_to = 1'b1; step("R11 timeout");
    s_to = 1'b0; step("R11 timeout held");
    s_rxc = 0;  step("R11 timeout release");

    // R10 single-transfer receive ready
    s_dm = 1'b0;
    s_rxc = 1; step("R10 one byte");
    s_rxc = 5; step("R10 bytes");
    s_rxc = 0; step("R10 empty");

    // R7 / R8 FIFO disabled: select ignored, levels are 1
    s_fen = 1'b0; s_dm = 1'b1;
    s_rxc = 1; s_txc = 1; step("R7 fifo off");
    s_rxc = 0; s_txc = 0; step("R7 fifo off empty");
    s_txc = 1; step("R8 holding full");
    s_txc = 0; step("R8 holding empty");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule